// File: doc/BRIEF.md
# Program Counter with Shared Return Stack

This block holds the 13-bit instruction address of a small microcontroller core and decides, once per instruction cycle, where the next fetch comes from. The decoder supplies an operation code, an 11-bit literal target from the instruction word and the current page latch value. The core's interrupt logic supplies a one-cycle strobe when an interrupt is accepted. Without a control operation the address simply advances by one.

A jump target is built by placing the two page bits, taken from bits 4:3 of the page latch, above the 11-bit literal. Subroutine calls and interrupt entries save their return address in one shared 8-entry hardware stack. Both kinds of return restore the address from that stack. The stack is circular: pushing past its depth overwrites the oldest entry, and popping past empty reads a stale slot. Each of these misuse cases sets its own sticky error flag, which only reset clears.

The stack occupancy is tracked by a state machine with three states: `STK_EMPTY`, `STK_PART` (1 to 7 entries) and `STK_FULL` (8 entries). A push moves it from `STK_EMPTY` to `STK_PART`, and from `STK_PART` to `STK_FULL` when the seventh entry becomes the eighth. A pop moves it from `STK_FULL` to `STK_PART`, and from `STK_PART` to `STK_EMPTY` when the last entry leaves. A push in `STK_FULL` stays in `STK_FULL` and raises the overflow flag. A pop in `STK_EMPTY` stays in `STK_EMPTY` and raises the underflow flag.

Top module: `pcstk_top`

## Requirements
- R1: After reset the PC is 0x000, both error flags are 0 and the stack is empty.
- R2: With op code NEXT (3'd0), or any unused code (3'd5, 3'd6, 3'd7), and no interrupt, the PC advances by one each cycle and wraps from 0x1FFF to 0x000.
- R3: With op code GOTO (3'd1) the PC loads {page[4:3], lit[10:0]}, and the stack is left unchanged.
- R4: With op code CALL (3'd2) the PC loads {page[4:3], lit[10:0]}, and PC+1 is pushed onto the return stack.
- R5: Op codes RETURN (3'd3) and RETFIE (3'd4) both pop the most recently pushed address into the PC, in last-in first-out order.
- R6: When the interrupt strobe is high, the PC loads 0x004 and PC+1 is pushed, whatever op code is present in that cycle. The op code is ignored.
- R7: Calls and interrupt entries share one stack, and up to 8 nested entries of either kind return correctly.
- R8: A push while 8 entries are held overwrites the oldest entry and sets the overflow flag, which stays set until reset.
- R9: A pop while the stack is empty sets the underflow flag, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Decoded control operation code |
| lit_i | input | 11 | Literal jump or call target |
| page_i | input | 5 | Page latch value; bits 4:3 are used |
| irq_take_i | input | 1 | One-cycle strobe for an accepted interrupt |
| pc_o | output | 13 | Current program counter |
| stk_ovf_o | output | 1 | Sticky stack overflow flag |
| stk_unf_o | output | 1 | Sticky stack underflow flag |

## Verification
The hardest situation to reach is an overflowed stack being unwound. After nine pushes, the ninth return address must sit where the first one was. The eight pops that follow must return the ninth address down to the second, and a further pop must then raise underflow. The bench reaches this state by mixing calls and interrupt strobes over nine levels, with a distinct target at each level. It then unwinds the stack with alternating RETURN and RETFIE and compares every popped PC against an arithmetic model of the circular stack. The same model is used for a sweep of jump targets over all page values, for the wrap at the top of the address space, and for an interrupt that coincides with a CALL.

// File: rtl/pcstk_pkg.sv
package pcstk_pkg;

    typedef enum logic [2:0] {
        OP_NEXT   = 3'd0,
        OP_GOTO   = 3'd1,
        OP_CALL   = 3'd2,
        OP_RETURN = 3'd3,
        OP_RETFIE = 3'd4
    } pc_op_e;

    typedef enum logic [1:0] {
        STK_EMPTY = 2'd0,
        STK_PART  = 2'd1,
        STK_FULL  = 2'd2
    } stk_state_e;

endpackage

// File: rtl/pcstk_next.sv
module pcstk_next #(
    parameter int PC_W   = 13,
    parameter int LIT_W  = 11,
    parameter int PAGE_W = 5,
    parameter int PG_LO  = 3,
    parameter int VECTOR = 4
) (
    input  logic [2:0]        op_i,
    input  logic [LIT_W-1:0]  lit_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              irq_take_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [PC_W-1:0]   top_i,
    output logic [PC_W-1:0]   pc_nxt_o,
    output logic              push_o,
    output logic              pop_o,
    output logic [PC_W-1:0]   push_data_o
);
    import pcstk_pkg::*;

    localparam int PG_BITS = PC_W - LIT_W;
    localparam int PG_HI   = PG_LO + PG_BITS - 1;

    logic [PC_W-1:0] seq_addr;
    logic [PC_W-1:0] jump_addr;
    pc_op_e          op;

    assign op          = pc_op_e'(op_i);
    assign seq_addr    = pc_i + 1'b1;
    assign jump_addr   = {page_i[PG_HI:PG_LO], lit_i};
    assign push_data_o = seq_addr;

    always_comb begin
        pc_nxt_o = seq_addr;
        push_o   = 1'b0;
        pop_o    = 1'b0;
        if (irq_take_i) begin
            pc_nxt_o = PC_W'(VECTOR);
            push_o   = 1'b1;
        end else begin
            unique case (op)
                OP_GOTO: pc_nxt_o = jump_addr;
                OP_CALL: begin
                    pc_nxt_o = jump_addr;
                    push_o   = 1'b1;
                end
                OP_RETURN, OP_RETFIE: begin
                    pc_nxt_o = top_i;
                    pop_o    = 1'b1;
                end
                default: pc_nxt_o = seq_addr;
            endcase
        end
    end

endmodule

// File: rtl/pcstk_stack.sv
module pcstk_stack #(
    parameter int WIDTH = 13,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic [WIDTH-1:0] top_o,
    output logic             ovf_o,
    output logic             unf_o
);
    import pcstk_pkg::*;

    localparam int SP_W  = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [SP_W-1:0]  sp;
    logic [SP_W-1:0]  sp_dec;
    logic [CNT_W-1:0] cnt;
    stk_state_e       state, state_nxt;

    assign sp_dec = sp - 1'b1;
    assign top_o  = mem[sp_dec];

    always_comb begin
        state_nxt = state;
        unique case (state)
            STK_EMPTY: if (push_i) state_nxt = (DEPTH == 1) ? STK_FULL : STK_PART;
            STK_PART: begin
                if (push_i && cnt == CNT_W'(DEPTH - 1)) state_nxt = STK_FULL;
                else if (pop_i && cnt == CNT_W'(1))     state_nxt = STK_EMPTY;
            end
            STK_FULL: if (pop_i) state_nxt = (DEPTH == 1) ? STK_EMPTY : STK_PART;
            default:  state_nxt = STK_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= STK_EMPTY;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp    <= '0;
            cnt   <= '0;
            ovf_o <= 1'b0;
            unf_o <= 1'b0;
        end else if (push_i) begin
            sp <= sp + 1'b1;
            if (state == STK_FULL) ovf_o <= 1'b1;
            else                   cnt   <= cnt + 1'b1;
        end else if (pop_i) begin
            sp <= sp_dec;
            if (state == STK_EMPTY) unf_o <= 1'b1;
            else                    cnt   <= cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i) mem[sp] <= push_data_i;
    end

endmodule

// File: rtl/pcstk_top.sv
module pcstk_top #(
    parameter int PC_W   = 13,
    parameter int LIT_W  = 11,
    parameter int PAGE_W = 5,
    parameter int PG_LO  = 3,
    parameter int DEPTH  = 8,
    parameter int VECTOR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_i,
    input  logic [LIT_W-1:0]  lit_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              irq_take_i,
    output logic [PC_W-1:0]   pc_o,
    output logic              stk_ovf_o,
    output logic              stk_unf_o
);
    logic [PC_W-1:0] pc_nxt;
    logic [PC_W-1:0] top_addr;
    logic [PC_W-1:0] push_data;
    logic            push;
    logic            pop;

    pcstk_next #(
        .PC_W(PC_W), .LIT_W(LIT_W), .PAGE_W(PAGE_W), .PG_LO(PG_LO), .VECTOR(VECTOR)
    ) next_i (
        .op_i(op_i), .lit_i(lit_i), .page_i(page_i), .irq_take_i(irq_take_i),
        .pc_i(pc_o), .top_i(top_addr), .pc_nxt_o(pc_nxt),
        .push_o(push), .pop_o(pop), .push_data_o(push_data)
    );

    pcstk_stack #(
        .WIDTH(PC_W), .DEPTH(DEPTH)
    ) stack_i (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
        .push_data_i(push_data), .top_o(top_addr),
        .ovf_o(stk_ovf_o), .unf_o(stk_unf_o)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) pc_o <= '0;
        else        pc_o <= pc_nxt;
    end

endmodule

// File: rtl/pcstk_chk.sv
module pcstk_chk #(
    parameter int PC_W   = 13,
    parameter int LIT_W  = 11,
    parameter int PAGE_W = 5,
    parameter int PG_LO  = 3,
    parameter int VECTOR = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        op_i,
    input logic [LIT_W-1:0]  lit_i,
    input logic [PAGE_W-1:0] page_i,
    input logic              irq_take_i,
    input logic [PC_W-1:0]   pc_o,
    input logic              stk_ovf_o,
    input logic              stk_unf_o
);
    localparam int PG_HI = PG_LO + PC_W - LIT_W - 1;

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (pc_o == '0 && !stk_ovf_o && !stk_unf_o)); // R1

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take_i && op_i == 3'd0) |=> pc_o == PC_W'($past(pc_o) + 1'b1)); // R2

    AST_GOTO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_take_i && (op_i == 3'd1 || op_i == 3'd2))
        |=> pc_o == {$past(page_i[PG_HI:PG_LO]), $past(lit_i)}); // R3

    AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take_i |=> pc_o == PC_W'(VECTOR)); // R6

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stk_ovf_o |=> stk_ovf_o); // R8

    AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        stk_unf_o |=> stk_unf_o); // R9

endmodule

bind pcstk_top pcstk_chk #(
    .PC_W(PC_W), .LIT_W(LIT_W), .PAGE_W(PAGE_W), .PG_LO(PG_LO), .VECTOR(VECTOR)
) chk_i (
    .clk(clk), .rst_n(rst_n), .op_i(op_i), .lit_i(lit_i), .page_i(page_i),
    .irq_take_i(irq_take_i), .pc_o(pc_o), .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o)
);

// File: tb/pcstk_tb.sv
module pcstk_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [10:0] lit_i = '0;
    logic [4:0]  page_i = '0;
    logic        irq_take_i = 1'b0;
    logic [12:0] pc_o;
    logic        stk_ovf_o;
    logic        stk_unf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [12:0] m_pc;
    logic [12:0] m_mem [DEPTH];
    int          m_sp, m_cnt;
    bit          m_ovf, m_unf;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcstk_top dut_i (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .lit_i(lit_i), .page_i(page_i),
        .irq_take_i(irq_take_i), .pc_o(pc_o), .stk_ovf_o(stk_ovf_o), .stk_unf_o(stk_unf_o)
    );

    task automatic check(string req, logic [12:0] act, logic [12:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic m_push(logic [12:0] v);
        if (m_cnt == DEPTH) m_ovf = 1'b1;
        else                m_cnt++;
        m_mem[m_sp] = v;
        m_sp = (m_sp + 1) % DEPTH;
    endtask

    task automatic m_pop();
        if (m_cnt == 0) m_unf = 1'b1;
        else            m_cnt--;
        m_sp = (m_sp + DEPTH - 1) % DEPTH;
        m_pc = m_mem[m_sp];
    endtask

    // Apply one instruction cycle, update the model, compare after the edge.
    task automatic step(string req, logic [2:0] op, logic [10:0] lit,
                        logic [4:0] pg, logic irq);
        logic [12:0] seq;
        op_i = op; lit_i = lit; page_i = pg; irq_take_i = irq;
        seq = m_pc + 13'd1;
        if (irq) begin
            m_push(seq); m_pc = 13'h004;
        end else begin
            case (op)
                3'd1: m_pc = {pg[4:3], lit};
                3'd2: begin m_push(seq); m_pc = {pg[4:3], lit}; end
                3'd3, 3'd4: m_pop();
                default: m_pc = seq;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(req, pc_o, m_pc);
        check({req, " ovf"}, {12'd0, stk_ovf_o}, {12'd0, m_ovf});
        check({req, " unf"}, {12'd0, stk_unf_o}, {12'd0, m_unf});
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_pc = '0; m_sp = 0; m_cnt = 0; m_ovf = 0; m_unf = 0;
        for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 pc", pc_o, 13'h000);
        check("R1 ovf", {12'd0, stk_ovf_o}, 13'd0);
        check("R1 unf", {12'd0, stk_unf_o}, 13'd0);

        // R2 sequential steps, including unused codes
        for (int i = 0; i < 4; i++) step("R2 next", 3'd0, 11'h123, 5'h1f, 1'b0);
        for (int c = 5; c < 8; c++) step("R2 unused code", 3'(c), 11'h7ff, 5'h18, 1'b0);

        // R3 sweep of jump targets over every page latch value
        for (int pg = 0; pg < 32; pg++)
            for (int k = 0; k < 4; k++)
                step("R3 goto", 3'd1, 11'(k * 11'h2a9 + pg), 5'(pg), 1'b0);

        // R2 wrap at the top of the address space
        step("R3 goto top", 3'd1, 11'h7ff, 5'h18, 1'b0);
        step("R2 wrap", 3'd0, 11'h0, 5'h0, 1'b0);

        // R4 R5 R7 nested calls and interrupts, 8 deep, then unwind
        for (int d = 0; d < DEPTH; d++) begin
            if (d % 3 == 2) step("R7 irq nest", 3'd1, 11'h0, 5'h0, 1'b1);
            else            step("R4 call nest", 3'd2, 11'(16 * d + 100), 5'(d << 3), 1'b0);
            step("R2 body", 3'd0, 11'h0, 5'h0, 1'b0);
        end
        for (int d = 0; d < DEPTH; d++)
            step("R5 return lifo", (d % 2 == 0) ? 3'd3 : 3'd4, 11'h0, 5'h0, 1'b0);

        // R6 interrupt coinciding with a CALL and with a RETURN
        step("R6 irq beats call", 3'd2, 11'h3c0, 5'h10, 1'b1);
        step("R6 irq beats return", 3'd3, 11'h0, 5'h0, 1'b1);
        step("R5 retfie", 3'd4, 11'h0, 5'h0, 1'b0);
        step("R5 return", 3'd3, 11'h0, 5'h0, 1'b0);

        // R8 nine pushes overwrite the oldest entry
        for (int d = 0; d < DEPTH + 1; d++) begin
            if (d % 2 == 1) step("R8 irq push", 3'd0, 11'h0, 5'h0, 1'b1);
            else            step("R8 call push", 3'd2, 11'(d * 37 + 5), 5'(d << 3), 1'b0);
        end
        for (int d = 0; d < DEPTH; d++)
            step("R8 unwind", (d % 2 == 0) ? 3'd4 : 3'd3, 11'h0, 5'h0, 1'b0);

        // R9 pop from empty
        step("R9 empty pop", 3'd3, 11'h0, 5'h0, 1'b0);
        step("R9 sticky", 3'd0, 11'h0, 5'h0, 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule